// File: doc/BRIEF.md
# Memory-Protection Region Register Bank

This block holds the configuration of a small set of memory-protection regions and answers, in the same cycle, whether a given access may proceed. Each region has a base word (lower bound, shareability, access permission, execute-never) and a limit word (upper bound and enable). Two complete copies exist, one for secure and one for non-secure software, and each copy has its own region-select register.

Software reaches the regions through a word-addressed register port. The main base/limit pair addresses the region named by the select register. Three further pairs reach the other members of the aligned group of four that the select register points into, so a driver can program four regions without rewriting the select register. Secure software can reach the non-secure copy through a second address window. Register reads answer one cycle after the request. The permission port takes an address, privilege level, access kind and security state, and returns allow or fault combinationally.

Top module: `mpu_region_bank`

## Requirements
- R1: Every request with `req_valid_i` high gives exactly one response cycle with `rsp_valid_o` high on the following cycle. Word slot 0 is the 8-bit region-select register, which is reset to 0. Slot 1 is the base word and slot 2 the limit word of the selected region. Read data is zero for writes, for faulted or errored requests and for slots 9 to 15.
- R2: Slots 3/4, 5/6 and 7/8 are the base/limit pairs of alias 1, 2 and 3. Alias n targets region index {select[7:2], n[1:0]}.
- R3: A request with `req_priv_i` low changes no state and responds with `rsp_fault_o` high.
- R4: A request with `req_size_i` other than 2 (0 byte, 1 half-word, 2 word) that is not faulted responds with `rsp_err_o` high and changes no state.
- R5: Address bit 4 selects the non-secure window. With bit 4 clear, the bank follows `req_sec_i` (1 secure, 0 non-secure). With bit 4 set, a secure request reaches the non-secure bank and a non-secure request faults.
- R6: A region index at or above NUM_REGIONS (default 8) reads as zero and ignores writes.
- R7: The base word stores all 32 bits. The limit word stores bits [31:5] and the enable bit 0, and bits [4:1] read as zero.
- R8: A region matches when it is enabled and {base[31:5],5'b0} <= address <= {limit[31:5],5'h1F}. If several regions match, the one with the highest index decides.
- R9: The permission code is base bits [2:1]. Bit 1 set allows any privilege level, and bit 2 set makes the region read-only. Reads (kind 0) are allowed if privileged or any-level. Writes (kind 1) additionally need read-only clear. Kind 3 is always denied.
- R10: A fetch (kind 2) is allowed when a read would be allowed and execute-never (base bit 0) is clear.
- R11: With no matching region, any access kind is allowed exactly when `chk_priv_i` is high. `chk_fault_o` is always the inverse of `chk_allow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 5 | Word address: bit 4 non-secure window, bits [3:0] slot |
| req_wdata_i | input | 32 | Write data |
| req_size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_priv_i | input | 1 | Requester is privileged |
| req_sec_i | input | 1 | Requester is secure |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Size error |
| rsp_fault_o | output | 1 | Bus fault |
| chk_addr_i | input | 32 | Address to check |
| chk_priv_i | input | 1 | Checked access is privileged |
| chk_kind_i | input | 2 | 0 read, 1 write, 2 fetch |
| chk_sec_i | input | 1 | Bank used for the check |
| chk_allow_o | output | 1 | Access allowed |
| chk_fault_o | output | 1 | Access denied |

## Verification
The hardest cases to reach are the alias pairs that point past NUM_REGIONS and overlapping regions where the higher index must override a more permissive lower one. The first case needs a select value of 8 or more combined with an alias slot. The random stimulus draws select values up to 11 and picks any slot, and a directed step writes alias 3 with select 4 and then reads region 7 through the main pair. For overlap, the bench programs nested regions with opposing permissions and probes both bounds, including the padded limit. It then randomises region bounds inside a small address window so that random check addresses hit several regions at once.

// File: rtl/mpu_bank_pkg.sv
`timescale 1ns/1ps
package mpu_bank_pkg;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_LO   = 5;
  localparam logic [1:0]  SIZE_WORD = 2'd2;
  localparam logic [DATA_W-1:0] LIMIT_KEEP = 32'hFFFF_FFE1;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic [DATA_W-ADDR_LO-1:0] lo;
    logic [DATA_W-ADDR_LO-1:0] hi;
    logic                      en;
    logic [1:0]                ap;
    logic                      xn;
  } rgn_t;

  // ap[0]: any privilege level, ap[1]: read-only
  function automatic logic perm_ok(logic [1:0] ap, logic xn, logic priv, logic [1:0] kind);
    logic rd;
    rd = priv | ap[0];
    case (kind)
      KIND_READ:  perm_ok = rd;
      KIND_WRITE: perm_ok = rd & ~ap[1];
      KIND_FETCH: perm_ok = rd & ~xn;
      default:    perm_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mpu_region_store.sv
`timescale 1ns/1ps
module mpu_region_store import mpu_bank_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wlimit_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o  [NUM_REGIONS],
  output logic [DATA_W-1:0] limit_o [NUM_REGIONS]
);
  // contents are undefined until software programs them
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    always_ff @(posedge clk_i) begin
      if (we_i && widx_i == IDX_W'(g)) begin
        if (wlimit_i) limit_o[g] <= wdata_i & LIMIT_KEEP;
        else          base_o[g]  <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/mpu_perm_check.sv
`timescale 1ns/1ps
module mpu_perm_check import mpu_bank_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  rgn_t              rgn_i [NUM_REGIONS],
  input  logic [DATA_W-1:0] addr_i,
  input  logic              priv_i,
  input  logic [1:0]        kind_i,
  output logic              hit_o,
  output logic              rule_ok_o
);
  logic [1:0] ap;
  logic       xn;

  always_comb begin
    hit_o = 1'b0;
    ap    = 2'b00;
    xn    = 1'b1;
    // ascending scan: the last match (highest index) wins
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rgn_i[i].en &&
          addr_i >= {rgn_i[i].lo, {ADDR_LO{1'b0}}} &&
          addr_i <= {rgn_i[i].hi, {ADDR_LO{1'b1}}}) begin
        hit_o = 1'b1;
        ap    = rgn_i[i].ap;
        xn    = rgn_i[i].xn;
      end
    end
    rule_ok_o = perm_ok(ap, xn, priv_i, kind_i);
  end
endmodule

// File: rtl/mpu_region_bank.sv
`timescale 1ns/1ps
module mpu_region_bank import mpu_bank_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned SEL_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [REG_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_priv_i,
  input  logic              req_sec_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              rsp_fault_o,
  input  logic [DATA_W-1:0] chk_addr_i,
  input  logic              chk_priv_i,
  input  logic [1:0]        chk_kind_i,
  input  logic              chk_sec_i,
  output logic              chk_allow_o,
  output logic              chk_fault_o
);
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [SEL_W:0] NREG = (SEL_W+1)'(NUM_REGIONS);

  logic [1:0][SEL_W-1:0] sel_q;          // index 1 secure, 0 non-secure
  logic [DATA_W-1:0]     base_w [2][NUM_REGIONS];
  logic [DATA_W-1:0]     lim_w  [2][NUM_REGIONS];

  logic [3:0]       slot;
  logic             ns_win, bank, fault, size_bad, acc_ok, acc_wr;
  logic             reg_slot, is_limit, in_range;
  logic [1:0]       alias_n;
  logic [SEL_W-1:0] sel_cur, idx_full;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_val;

  assign slot     = req_addr_i[3:0];
  assign ns_win   = req_addr_i[4];
  assign bank     = req_sec_i & ~ns_win;
  assign fault    = ~req_priv_i | (ns_win & ~req_sec_i);
  assign size_bad = req_size_i != SIZE_WORD;
  assign acc_ok   = req_valid_i & ~fault & ~size_bad;
  assign acc_wr   = acc_ok & req_write_i;

  assign sel_cur  = sel_q[bank];
  assign reg_slot = slot >= 4'd1 && slot <= 4'd8;
  assign is_limit = ~slot[0];
  assign alias_n  = 2'((slot - 4'd1) >> 1);
  assign idx_full = (alias_n == 2'd0) ? sel_cur : {sel_cur[SEL_W-1:2], alias_n};
  assign in_range = {1'b0, idx_full} < NREG;
  assign idx      = idx_full[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (acc_wr && slot == 4'd0) sel_q[bank] <= req_wdata_i[SEL_W-1:0];
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    mpu_region_store #(.NUM_REGIONS(NUM_REGIONS)) u_store (
      .clk_i   (clk_i),
      .we_i    (acc_wr && reg_slot && in_range && bank == 1'(b)),
      .wlimit_i(is_limit),
      .widx_i  (idx),
      .wdata_i (req_wdata_i),
      .base_o  (base_w[b]),
      .limit_o (lim_w[b])
    );
  end

  always_comb begin
    rd_val = '0;
    if (slot == 4'd0)
      rd_val = {{(DATA_W-SEL_W){1'b0}}, sel_cur};
    else if (reg_slot && in_range)
      rd_val = is_limit ? lim_w[bank][idx] : base_w[bank][idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (acc_ok && !req_write_i) ? rd_val : '0;
      rsp_err_o   <= req_valid_i & ~fault & size_bad;
      rsp_fault_o <= req_valid_i & fault;
    end
  end

  // permission path
  rgn_t chk_rgn [NUM_REGIONS];
  logic chk_hit, chk_rule_ok;

  always_comb begin
    for (int i = 0; i < NUM_REGIONS; i++) begin
      chk_rgn[i].lo = base_w[chk_sec_i][i][DATA_W-1:ADDR_LO];
      chk_rgn[i].ap = base_w[chk_sec_i][i][2:1];
      chk_rgn[i].xn = base_w[chk_sec_i][i][0];
      chk_rgn[i].hi = lim_w[chk_sec_i][i][DATA_W-1:ADDR_LO];
      chk_rgn[i].en = lim_w[chk_sec_i][i][0];
    end
  end

  mpu_perm_check #(.NUM_REGIONS(NUM_REGIONS)) u_check (
    .rgn_i    (chk_rgn),
    .addr_i   (chk_addr_i),
    .priv_i   (chk_priv_i),
    .kind_i   (chk_kind_i),
    .hit_o    (chk_hit),
    .rule_ok_o(chk_rule_ok)
  );

  assign chk_allow_o = chk_hit ? chk_rule_ok : chk_priv_i;
  assign chk_fault_o = ~chk_allow_o;
endmodule

// File: rtl/mpu_region_bank_sva.sv
`timescale 1ns/1ps
module mpu_region_bank_sva #(
  parameter int unsigned SEL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [4:0]       req_addr_i,
  input logic [1:0]       req_size_i,
  input logic             req_priv_i,
  input logic             req_sec_i,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_rdata_o,
  input logic             rsp_err_o,
  input logic             rsp_fault_o,
  input logic [1:0][SEL_W-1:0] sel_q,
  input logic             chk_hit,
  input logic             chk_priv_i,
  input logic             chk_allow_o,
  input logic             chk_fault_o
);
  p_resp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_resp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && rsp_rdata_o == '0);
  p_unpriv_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_priv_i |=> rsp_fault_o && rsp_rdata_o == '0 && !rsp_err_o);
  p_unpriv_keeps_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_priv_i |=> $stable(sel_q));
  p_size_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_priv_i && !(req_addr_i[4] && !req_sec_i) && req_size_i != 2'd2
      |=> rsp_err_o && !rsp_fault_o);
  p_size_keeps_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_size_i != 2'd2 |=> $stable(sel_q));
  p_ns_window_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[4] && !req_sec_i |=> rsp_fault_o);
  p_nomatch_unpriv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_hit && !chk_priv_i |-> !chk_allow_o);
  p_allow_fault_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_allow_o != chk_fault_o);
endmodule

bind mpu_region_bank mpu_region_bank_sva #(.SEL_W(SEL_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_size_i (req_size_i),
  .req_priv_i (req_priv_i),
  .req_sec_i  (req_sec_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_fault_o(rsp_fault_o),
  .sel_q      (sel_q),
  .chk_hit    (chk_hit),
  .chk_priv_i (chk_priv_i),
  .chk_allow_o(chk_allow_o),
  .chk_fault_o(chk_fault_o)
);

// File: tb/mpu_region_bank_bench.sv
`timescale 1ns/1ps
module mpu_region_bank_bench;
  localparam int NR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_priv = 0, req_sec = 0;
  logic [4:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] req_size = 2'd2;
  logic rsp_valid, rsp_err, rsp_fault;
  logic [31:0] rsp_rdata;
  logic [31:0] chk_addr = '0;
  logic chk_priv = 0, chk_sec = 0;
  logic [1:0] chk_kind = 0;
  logic chk_allow, chk_fault;

  int checks = 0, errors = 0;
  logic [31:0] m_base [2][NR];
  logic [31:0] m_lim  [2][NR];
  logic [7:0]  m_sel  [2];

  always #2.5 clk = ~clk;

  mpu_region_bank u_mpu_region_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_size_i(req_size), .req_priv_i(req_priv),
    .req_sec_i(req_sec), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .rsp_fault_o(rsp_fault),
    .chk_addr_i(chk_addr), .chk_priv_i(chk_priv), .chk_kind_i(chk_kind),
    .chk_sec_i(chk_sec), .chk_allow_o(chk_allow), .chk_fault_o(chk_fault));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // region index targeted by a slot, -1 when none
  function automatic int slot_idx(int b, int slot);
    int an;
    if (slot < 1 || slot > 8) return -1;
    an = (slot - 1) / 2;
    if (an == 0) return int'(m_sel[b]);
    return int'({m_sel[b][7:2], 2'(an)});
  endfunction

  // one bus op with model update and full response check
  task automatic bus(bit wr, logic [4:0] a, logic [31:0] d, logic [1:0] sz, bit pv, bit sc);
    bit flt, er, ok;
    int b, slot, idx;
    logic [31:0] exp_rd;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    req_size = sz; req_priv = pv; req_sec = sc;
    flt = !pv || (a[4] && !sc);
    er  = !flt && sz != 2'd2;
    ok  = !flt && !er;
    b = (sc && !a[4]) ? 1 : 0;
    slot = int'(a[3:0]);
    idx = slot_idx(b, slot);
    exp_rd = '0;
    if (ok && !wr) begin
      if (slot == 0) exp_rd = {24'h0, m_sel[b]};
      else if (idx >= 0 && idx < NR) exp_rd = slot[0] ? m_base[b][idx] : m_lim[b][idx];
    end
    @(negedge clk);
    req_valid = 0;
    check("R1 rsp_valid", 32'(rsp_valid), 32'd1);
    check(!pv ? "R3 fault" : "R5 fault", 32'(rsp_fault), 32'(flt));
    check("R4 err", 32'(rsp_err), 32'(er));
    check(idx >= NR ? "R6 rdata" : (slot > 2 ? "R2 rdata" : "R1 rdata"), rsp_rdata, exp_rd);
    if (ok && wr) begin
      if (slot == 0) m_sel[b] = d[7:0];
      else if (idx >= 0 && idx < NR) begin
        if (slot[0]) m_base[b][idx] = d;
        else m_lim[b][idx] = d & 32'hFFFF_FFE1;
      end
    end
  endtask

  function automatic bit exp_allow(int b, logic [31:0] a, bit pv, logic [1:0] k);
    bit hit = 0, rd;
    logic [1:0] ap = 0;
    bit xn = 0;
    for (int i = 0; i < NR; i++)
      if (m_lim[b][i][0] && a >= {m_base[b][i][31:5], 5'h0} && a <= {m_lim[b][i][31:5], 5'h1F}) begin
        hit = 1; ap = m_base[b][i][2:1]; xn = m_base[b][i][0];
      end
    if (!hit) return pv;
    rd = pv || ap[0];
    case (k)
      2'd0: return rd;
      2'd1: return rd && !ap[1];
      2'd2: return rd && !xn;
      default: return 0;
    endcase
  endfunction

  task automatic pcheck(string tag, bit sc, logic [31:0] a, bit pv, logic [1:0] k);
    bit e;
    @(negedge clk);
    chk_sec = sc; chk_addr = a; chk_priv = pv; chk_kind = k;
    #1;
    e = exp_allow(sc ? 1 : 0, a, pv, k);
    check(tag, 32'(chk_allow), 32'(e));
    check("R11 fault inverse", 32'(chk_fault), 32'(!e));
  endtask

  task automatic set_rgn(bit sc, int i, logic [31:0] base, logic [31:0] lim);
    bus(1, 5'(sc ? 0 : 0), 32'(i), 2'd2, 1, sc);
    bus(1, 5'd1, base, 2'd2, 1, sc);
    bus(1, 5'd2, lim, 2'd2, 1, sc);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_sel[0] = 0; m_sel[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R1 reset fault", 32'(rsp_fault), 0);
    rst_n = 1;
    bus(0, 5'd0, 0, 2'd2, 1, 1);   // R1 select reset value, secure
    bus(0, 5'd0, 0, 2'd2, 1, 0);   // R1 select reset value, non-secure

    // program every region of both banks, all disabled
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NR; i++)
        set_rgn(b[0], i, $urandom, $urandom & 32'hFFFF_FFFE);

    // R7 limit masking
    set_rgn(1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    bus(0, 5'd2, 0, 2'd2, 1, 1);
    bus(0, 5'd1, 0, 2'd2, 1, 1);
    set_rgn(1, 3, 32'h0, 32'h0);

    // R2 alias 3 with select 4 reaches region 7
    bus(1, 5'd0, 4, 2'd2, 1, 1);
    bus(1, 5'd7, 32'hCAFE_0015, 2'd2, 1, 1);
    bus(1, 5'd0, 7, 2'd2, 1, 1);
    bus(0, 5'd1, 0, 2'd2, 1, 1);
    // R6 out-of-range select
    bus(1, 5'd0, 9, 2'd2, 1, 1);
    bus(1, 5'd1, 32'h1234_5678, 2'd2, 1, 1);
    bus(0, 5'd1, 0, 2'd2, 1, 1);
    bus(0, 5'd3, 0, 2'd2, 1, 1);
    // R5 secure through window reaches non-secure bank
    bus(1, 5'h10, 5, 2'd2, 1, 1);
    bus(1, 5'h11, 32'hA5A5_0000, 2'd2, 1, 1);
    bus(0, 5'h01, 0, 2'd2, 1, 0);
    bus(1, 5'h10, 2, 2'd2, 1, 0);  // non-secure into window: fault
    // R3 unprivileged write, R4 byte write, each then read back
    bus(1, 5'd0, 1, 2'd2, 0, 1);
    bus(0, 5'd0, 0, 2'd2, 1, 1);
    bus(1, 5'd0, 2, 2'd0, 1, 1);
    bus(0, 5'd0, 0, 2'd2, 1, 1);
    bus(1, 5'd0, 3, 2'd1, 1, 0);
    bus(0, 5'd0, 0, 2'd2, 1, 0);

    // random register traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      logic [31:0] d;
      int r;
      a = {($urandom % 6 == 0) ? 1'b1 : 1'b0, 4'($urandom % 10)};
      r = int'($urandom % 12);
      d = (a[3:0] == 0) ? 32'($urandom % 12) : $urandom;
      bus(r < 6, a, d, (r == 11) ? 2'($urandom % 2) : 2'd2, r != 10, 1'($urandom));
    end

    // directed overlap in the secure bank
    for (int i = 0; i < NR; i++) set_rgn(1, i, 32'h0, 32'h0);
    set_rgn(1, 2, 32'h0000_1002, 32'h0000_1FE1);  // any level, RW, exec
    set_rgn(1, 5, 32'h0000_1805, 32'h0000_18E1);  // priv only, RO, XN
    pcheck("R8 lower region outside upper", 1, 32'h0000_1900, 0, 2'd0);
    pcheck("R8 higher index wins", 1, 32'h0000_1880, 0, 2'd0);
    pcheck("R8 base bound inclusive", 1, 32'h0000_1800, 0, 2'd0);
    pcheck("R8 below base", 1, 32'h0000_17FF, 0, 2'd1);
    pcheck("R8 padded limit", 1, 32'h0000_18FF, 0, 2'd0);
    pcheck("R9 priv read of RO", 1, 32'h0000_1880, 1, 2'd0);
    pcheck("R9 priv write of RO", 1, 32'h0000_1880, 1, 2'd1);
    pcheck("R9 unpriv write any level", 1, 32'h0000_1100, 0, 2'd1);
    pcheck("R9 kind 3 denied", 1, 32'h0000_1100, 1, 2'd3);
    pcheck("R10 fetch XN", 1, 32'h0000_1880, 1, 2'd2);
    pcheck("R10 fetch allowed", 1, 32'h0000_1100, 0, 2'd2);
    pcheck("R11 no match priv", 1, 32'h0000_9000, 1, 2'd1);
    pcheck("R11 no match unpriv", 1, 32'h0000_9000, 0, 2'd0);

    // random overlapping regions within a small window
    for (int round = 0; round < 4; round++) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NR; i++) begin
          logic [31:0] lo;
          lo = $urandom & 32'h0000_3FE0;
          set_rgn(b[0], i, lo | ($urandom & 32'h1F),
                  ((lo + ($urandom & 32'h0000_0FE0)) & 32'hFFFF_FFE0) | 32'($urandom % 4 != 0));
        end
      for (int n = 0; n < 150; n++)
        pcheck("R8 R9 R10 random check", 1'($urandom), $urandom & 32'h0000_4FFF,
               1'($urandom), 2'($urandom % 4));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule